// File: doc/BRIEF.md
# Parallel Parsimony First-Pass Scorer

This block runs the bottom-up pass of small-parsimony scoring over a binary tree. A caller loads a list of internal node identifiers in an order where every child precedes its parent. The caller then pulses `start` with the number of nodes. The block walks the list one node per clock. For each node it fetches the topology word, which holds references to two children, and reads both children as rows of per-character 5-bit state sets. A child row comes from leaf memory or from node-state memory. One processing element per character forms the preliminary state of the new node, and the block writes that row back into node-state memory at the node's identifier.

Each processing element also reports whether its character needed a change at this node. A registered adder tree counts these flags. The block accumulates the count for every node into a total tree length and reports it with a one-cycle `done` pulse. A node may consume the result of the node processed one or two slots before it. Those results have not yet reached memory, so the block forwards them internally. The list therefore streams with no stalls and completes in a fixed number of cycles.

Top module: `pars_first_pass`

## Requirements
- R1: A character state is a 5-bit set: bit 0 A, bit 1 C, bit 2 G, bit 3 T, bit 4 gap; undefined and ambiguous characters set several bits. For children a and b, the new state is a&b when that is non-zero, with no change counted. Otherwise the new state is a|b and one change is counted. Every 5-bit pair, including the empty set, follows this rule.
- R2: Character j of a row occupies bits [5j+4:5j]. All NUM_CHARS characters of a node are computed in the same cycle, and the resulting row is written once to node-state memory at the node's identifier.
- R3: The topology word at a node's identifier holds the left child reference in its upper NODE_W+1 bits and the right child reference in the lower NODE_W+1 bits. A reference's top bit is 1 for a leaf (read from leaf memory) and 0 for an internal node (read from node-state memory); its lower NODE_W bits are the identifier.
- R4: Nodes are taken from list positions 0 to n-1 in order, one per cycle. A parent whose child was processed one or two positions earlier still receives that child's new row.
- R5: `score` equals the total number of counted changes over every character of every listed node.
- R6: With n > 0, `done` is high for exactly one cycle, n + log2(NUM_CHARS) + 4 clock edges after the edge that samples `start`. `score` carries the result in that cycle and keeps it until a later run completes.
- R7: A start with a node count of zero produces `done` on the edge that samples `start`, with `score` equal to zero, and issues no memory write.
- R8: `start` has no effect while a run is in progress. The running list finishes with its own score and `done` appears only once.
- R9: Under reset, `done` is low, `score` is zero and no node-state write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, sampled when idle |
| node_count | input | NODE_W | Number of list entries for the run |
| done | output | 1 | One-cycle completion pulse |
| score | output | NODE_W+clog2(NUM_CHARS+1) | Total tree length of the last run |
| ord_addr | output | NODE_W | Node list read address |
| ord_data | input | NODE_W | Node list read data, one cycle after address |
| topo_addr | output | NODE_W | Topology read address |
| topo_data | input | 2*(NODE_W+1) | Topology word: left reference, right reference |
| leaf_addr_l | output | NODE_W | Leaf read address, left child |
| leaf_data_l | input | 5*NUM_CHARS | Leaf row, left child |
| leaf_addr_r | output | NODE_W | Leaf read address, right child |
| leaf_data_r | input | 5*NUM_CHARS | Leaf row, right child |
| node_addr_l | output | NODE_W | Node-state read address, left child |
| node_data_l | input | 5*NUM_CHARS | Node-state row, left child |
| node_addr_r | output | NODE_W | Node-state read address, right child |
| node_data_r | input | 5*NUM_CHARS | Node-state row, right child |
| node_we | output | 1 | Node-state write enable |
| node_waddr | output | NODE_W | Node-state write address |
| node_wdata | output | 5*NUM_CHARS | Node-state write row |

## Verification
The bench builds the block with NODE_W = 4 and NUM_CHARS = 4. With this configuration the adder tree is two levels deep, and every one of the 1024 pairs of 5-bit child sets can be driven through the processing elements in 256 single-node runs. Trees of up to 16 leaves exercise the full list range. Chain-shaped trees force forwarding from one slot back, balanced trees reach forwarding from two slots back and plain memory reads, and randomly joined trees with swapped sides mix all three paths. The bench's own model recomputes every node row and the score, and the bench measures the exact latency of every run.

// File: rtl/pars_pkg.sv
package pars_pkg;
  localparam int SYM_W = 5;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/pars_pe.sv
module pars_pe
  import pars_pkg::*;
(
  input  sym_t a,
  input  sym_t b,
  output sym_t st,
  output logic chg
);
  sym_t common;

  always_comb begin
    common = a & b;
    chg    = (common == '0);
    st     = chg ? (a | b) : common;
  end
endmodule

// File: rtl/pars_adder_tree.sv
// Registered binary reduction of N single-bit flags; latency = clog2(N), N >= 2.
module pars_adder_tree #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [N-1:0]  in_bits,
  output logic          out_v,
  output logic [CW-1:0] out_sum
);
  localparam int DEPTH = $clog2(N);
  localparam int NP    = 1 << DEPTH;

  logic [NP-1:0] padded;
  logic [CW-1:0] leaf [NP];
  logic [CW-1:0] acc  [1:NP-1];
  logic [DEPTH-1:0] vpipe;

  assign padded = NP'(in_bits);

  always_comb begin
    for (int i = 0; i < NP; i++) leaf[i] = CW'(padded[i]);
  end

  // heap layout: acc[1] is the root, acc[i] sums children 2i and 2i+1
  for (genvar i = 1; i < NP; i++) begin : g_node
    if (2 * i >= NP) begin : g_bottom
      always_ff @(posedge clk) acc[i] <= leaf[2*i-NP] + leaf[2*i-NP+1];
    end else begin : g_inner
      always_ff @(posedge clk) acc[i] <= acc[2*i] + acc[2*i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else begin
      vpipe[0] <= in_v;
      for (int d = 1; d < DEPTH; d++) vpipe[d] <= vpipe[d-1];
    end
  end

  assign out_v   = vpipe[DEPTH-1];
  assign out_sum = acc[1];

  assert_sum_bound_R5: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_sum <= CW'(N)));
endmodule

// File: rtl/pars_first_pass.sv
module pars_first_pass
  import pars_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int NUM_CHARS = 4,
  localparam int REF_W    = NODE_W + 1,
  localparam int TOPO_W   = 2 * REF_W,
  localparam int ROW_W    = NUM_CHARS * SYM_W,
  localparam int CNT_W    = $clog2(NUM_CHARS + 1),
  localparam int SCORE_W  = NODE_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NODE_W-1:0]  node_count,
  output logic               done,
  output logic [SCORE_W-1:0] score,
  output logic [NODE_W-1:0]  ord_addr,
  input  logic [NODE_W-1:0]  ord_data,
  output logic [NODE_W-1:0]  topo_addr,
  input  logic [TOPO_W-1:0]  topo_data,
  output logic [NODE_W-1:0]  leaf_addr_l,
  input  logic [ROW_W-1:0]   leaf_data_l,
  output logic [NODE_W-1:0]  leaf_addr_r,
  input  logic [ROW_W-1:0]   leaf_data_r,
  output logic [NODE_W-1:0]  node_addr_l,
  input  logic [ROW_W-1:0]   node_data_l,
  output logic [NODE_W-1:0]  node_addr_r,
  input  logic [ROW_W-1:0]   node_data_r,
  output logic               node_we,
  output logic [NODE_W-1:0]  node_waddr,
  output logic [ROW_W-1:0]   node_wdata
);
  // ---------------- run control ----------------
  logic              busy, iss_v, start_ok, fin;
  logic [NODE_W-1:0] total, got, ord_q;
  logic [SCORE_W-1:0] acc;
  logic              sum_v;
  logic [CNT_W-1:0]  sum_out;

  assign start_ok = start && !busy && !done;
  assign fin      = sum_v && (got == total - 1'b1);
  assign ord_addr = ord_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      iss_v <= 1'b0;
      ord_q <= '0;
      total <= '0;
      got   <= '0;
      acc   <= '0;
      done  <= 1'b0;
      score <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        total <= node_count;
        ord_q <= '0;
        got   <= '0;
        acc   <= '0;
        iss_v <= (node_count != '0);
        busy  <= (node_count != '0);
        if (node_count == '0) begin
          done  <= 1'b1;
          score <= '0;
        end
      end else begin
        if (iss_v) begin
          if (ord_q == total - 1'b1) iss_v <= 1'b0;
          else ord_q <= ord_q + 1'b1;
        end
        if (sum_v) begin
          acc <= acc + SCORE_W'(sum_out);
          got <= got + 1'b1;
          if (fin) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            score <= acc + SCORE_W'(sum_out);
          end
        end
      end
    end
  end

  // ---------------- node pipeline ----------------
  // B: list data back, topology read issued
  // C: topology back, child rows read issued
  // D: child rows back, states computed
  // E: result row written; F: previous write kept for forwarding
  logic              v_b, v_c, v_d, v_e, v_f;
  logic [NODE_W-1:0] id_c, id_d, id_e, id_f;
  logic [REF_W-1:0]  lref_c, rref_c, lref_d, rref_d;
  logic [ROW_W-1:0]  st_e, st_f, opl, opr, pe_row;
  logic [NUM_CHARS-1:0] chg_e, pe_chg;

  assign topo_addr   = ord_data;
  assign lref_c      = topo_data[TOPO_W-1:REF_W];
  assign rref_c      = topo_data[REF_W-1:0];
  assign leaf_addr_l = lref_c[NODE_W-1:0];
  assign node_addr_l = lref_c[NODE_W-1:0];
  assign leaf_addr_r = rref_c[NODE_W-1:0];
  assign node_addr_r = rref_c[NODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_b <= 1'b0;
      v_c <= 1'b0;
      v_d <= 1'b0;
      v_e <= 1'b0;
      v_f <= 1'b0;
    end else begin
      v_b <= iss_v;
      v_c <= v_b;
      v_d <= v_c;
      v_e <= v_d;
      v_f <= v_e;
    end
  end

  always_ff @(posedge clk) begin
    id_c   <= ord_data;
    id_d   <= id_c;
    lref_d <= lref_c;
    rref_d <= rref_c;
    id_e   <= id_d;
    st_e   <= pe_row;
    chg_e  <= pe_chg;
    id_f   <= id_e;
    st_f   <= st_e;
  end

  // operand select: leaf row, or newest in-flight node row, or memory row
  always_comb begin
    if (lref_d[NODE_W])                            opl = leaf_data_l;
    else if (v_e && id_e == lref_d[NODE_W-1:0])    opl = st_e;
    else if (v_f && id_f == lref_d[NODE_W-1:0])    opl = st_f;
    else                                           opl = node_data_l;
    if (rref_d[NODE_W])                            opr = leaf_data_r;
    else if (v_e && id_e == rref_d[NODE_W-1:0])    opr = st_e;
    else if (v_f && id_f == rref_d[NODE_W-1:0])    opr = st_f;
    else                                           opr = node_data_r;
  end

  for (genvar j = 0; j < NUM_CHARS; j++) begin : g_pe
    pars_pe u_pe (
      .a  (opl[j*SYM_W +: SYM_W]),
      .b  (opr[j*SYM_W +: SYM_W]),
      .st (pe_row[j*SYM_W +: SYM_W]),
      .chg(pe_chg[j])
    );
  end

  assign node_we    = v_e;
  assign node_waddr = id_e;
  assign node_wdata = st_e;

  pars_adder_tree #(.N(NUM_CHARS), .CW(CNT_W)) u_tree (
    .clk    (clk),
    .rst    (rst),
    .in_v   (v_e),
    .in_bits(chg_e),
    .out_v  (sum_v),
    .out_sum(sum_out)
  );

  // ---------------- assertions ----------------
  assert_write_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    node_we |-> busy);
  assert_issue_range_R4: assert property (@(posedge clk) disable iff (rst)
    iss_v |-> (ord_q < total));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_score_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(score));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(total));
  assert_zero_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (start_ok && node_count == '0) |=> !node_we);
endmodule

// File: tb/test_pars_first_pass.sv
module test_pars_first_pass;
  localparam int NW  = 4;
  localparam int LC  = 4;
  localparam int ROW = 5 * LC;
  localparam int RF  = NW + 1;
  localparam int SW  = NW + $clog2(LC + 1);
  localparam int TD  = $clog2(LC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NW-1:0] node_count = '0;
  logic done;
  logic [SW-1:0] score;
  logic [NW-1:0] ord_addr, topo_addr, leaf_addr_l, leaf_addr_r, node_addr_l, node_addr_r, node_waddr;
  logic [NW-1:0] ord_q;
  logic [2*RF-1:0] topo_q;
  logic [ROW-1:0] leafl_q, leafr_q, nodel_q, noder_q, node_wdata;
  logic node_we;
  logic clr = 1'b0;

  logic [NW-1:0]   ord_mem  [16];
  logic [2*RF-1:0] topo_mem [16];
  logic [ROW-1:0]  leaf_mem [16];
  logic [ROW-1:0]  node_mem [16];
  logic [ROW-1:0]  exp_st   [16];
  logic [RF-1:0]   pool     [16];
  logic [RF-1:0]   tmp      [16];

  int nvec = 0, nfail = 0, nnodes, exp_score;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  pars_first_pass #(.NODE_W(NW), .NUM_CHARS(LC)) i_pars_first_pass (
    .clk(clk), .rst(rst), .start(start), .node_count(node_count),
    .done(done), .score(score),
    .ord_addr(ord_addr), .ord_data(ord_q),
    .topo_addr(topo_addr), .topo_data(topo_q),
    .leaf_addr_l(leaf_addr_l), .leaf_data_l(leafl_q),
    .leaf_addr_r(leaf_addr_r), .leaf_data_r(leafr_q),
    .node_addr_l(node_addr_l), .node_data_l(nodel_q),
    .node_addr_r(node_addr_r), .node_data_r(noder_q),
    .node_we(node_we), .node_waddr(node_waddr), .node_wdata(node_wdata)
  );

  // synchronous memories, one-cycle read latency
  always @(posedge clk) begin
    ord_q   <= ord_mem[ord_addr];
    topo_q  <= topo_mem[topo_addr];
    leafl_q <= leaf_mem[leaf_addr_l];
    leafr_q <= leaf_mem[leaf_addr_r];
    nodel_q <= node_mem[node_addr_l];
    noder_q <= node_mem[node_addr_r];
    if (clr) for (int q = 0; q < 16; q++) node_mem[q] <= '0;
    else if (node_we) node_mem[node_waddr] <= node_wdata;
  end

  function automatic int rnd(input int m);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]) % m;
  endfunction

  function automatic logic [ROW-1:0] m_row(input logic [ROW-1:0] a, input logic [ROW-1:0] b);
    logic [ROW-1:0] r;
    for (int j = 0; j < LC; j++) begin
      logic [4:0] x;
      x = a[j*5 +: 5] & b[j*5 +: 5];
      r[j*5 +: 5] = (x != 0) ? x : (a[j*5 +: 5] | b[j*5 +: 5]);
    end
    return r;
  endfunction

  function automatic int m_chg(input logic [ROW-1:0] a, input logic [ROW-1:0] b);
    int c = 0;
    for (int j = 0; j < LC; j++) if ((a[j*5 +: 5] & b[j*5 +: 5]) == 0) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [ROW-1:0] operand(input logic [RF-1:0] r);
    return r[NW] ? leaf_mem[r[NW-1:0]] : exp_st[r[NW-1:0]];
  endfunction

  task automatic model(input int n);
    exp_score = 0;
    for (int m = 0; m < n; m++) begin
      logic [NW-1:0] id;
      logic [ROW-1:0] a, b;
      id = ord_mem[m];
      a = operand(topo_mem[id][2*RF-1:RF]);
      b = operand(topo_mem[id][RF-1:0]);
      exp_st[id] = m_row(a, b);
      exp_score += m_chg(a, b);
    end
  endtask

  // shape 0: chain, 1: balanced, 2: random joins with random sides
  task automatic build(input int k, input int shape);
    int pn, i, j, c;
    logic [RF-1:0] x, y;
    logic [NW-1:0] id;
    for (int q = 0; q < k; q++) begin
      leaf_mem[q] = ROW'({rnd(1024), rnd(1024)} & 20'hFFFFF);
      leaf_mem[q] = {10'(rnd(1024)), 10'(rnd(1024))};
      pool[q] = {1'b1, NW'(q)};
    end
    pn = k;
    nnodes = 0;
    while (pn > 1) begin
      case (shape)
        0: begin i = 0; j = pn - 1; end
        1: begin i = 0; j = 1; end
        default: begin i = rnd(pn); j = rnd(pn - 1); if (j >= i) j++; end
      endcase
      x = pool[i];
      y = pool[j];
      c = 0;
      for (int q = 0; q < pn; q++) if (q != i && q != j) begin tmp[c] = pool[q]; c++; end
      for (int q = 0; q < c; q++) pool[q] = tmp[q];
      id = NW'((nnodes * 7 + 3) % 16);
      if (shape == 2 && rnd(2) == 1) topo_mem[id] = {y, x};
      else topo_mem[id] = {x, y};
      ord_mem[nnodes] = id;
      pool[pn-2] = {1'b0, id};
      pn--;
      nnodes++;
    end
  endtask

  task automatic run(input int n, input bit poke, input string req);
    int cyc, expl;
    logic [SW-1:0] held;
    model(n);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1; node_count = NW'(n);
    @(posedge clk);
    @(negedge clk); start = 1'b0; cyc = 0;
    while (!done && cyc < 400) begin
      if (poke && cyc == 3) begin start = 1'b1; node_count = '0; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    expl = (n == 0) ? 0 : n + 4 + TD;
    check(cyc == expl, {req, " R6 latency"}, cyc, expl);
    check(score == SW'(exp_score), {req, " R5 score"}, score, exp_score);
    held = score;
    @(negedge clk);
    check(done == 1'b0, {req, " R6 single pulse"}, done, 0);
    if (poke) begin
      bit again = 1'b0;
      for (int q = 0; q < 12; q++) begin @(negedge clk); if (done) again = 1'b1; end
      check(!again, "R8 no second done", again, 0);
      check(score == held, "R6 score held", score, held);
    end
    for (int m = 0; m < n; m++) begin
      logic [NW-1:0] id;
      id = ord_mem[m];
      check(node_mem[id] == exp_st[id], {req, " R2 R4 node row"}, node_mem[id], exp_st[id]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int q = 0; q < 16; q++) begin
      ord_mem[q] = '0; topo_mem[q] = '0; leaf_mem[q] = '0; exp_st[q] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R9 done in reset", done, 0);
    check(score == '0, "R9 score in reset", score, 0);
    check(node_we == 1'b0, "R9 no write in reset", node_we, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && node_we == 1'b0, "R9 idle after reset", {done, node_we}, 0);

    // R1: every pair of 5-bit child sets, four characters per single-node run
    for (int p = 0; p < 256; p++) begin
      logic [9:0] idx;
      logic [NW-1:0] nid;
      for (int j = 0; j < LC; j++) begin
        idx = 10'(p * 4 + j);
        leaf_mem[0][j*5 +: 5] = idx[9:5];
        leaf_mem[1][j*5 +: 5] = idx[4:0];
      end
      nid = NW'(p % 16);
      ord_mem[0] = nid;
      topo_mem[nid] = {1'b1, NW'(0), 1'b1, NW'(1)};
      run(1, 1'b0, "R1");
    end

    // R3 R4: chain (one-slot forwarding), balanced (two-slot and memory)
    build(16, 0); run(nnodes, 1'b0, "R3 chain");
    build(16, 1); run(nnodes, 1'b0, "R3 balanced");
    build(9, 1);  run(nnodes, 1'b0, "R4 balanced9");
    build(2, 0);  run(nnodes, 1'b0, "R4 single");
    for (int t = 0; t < 40; t++) begin
      build(2 + rnd(15), 2);
      run(nnodes, 1'b0, "R3 random");
    end

    // R7: empty list
    run(0, 1'b0, "R7 empty");
    check(node_we == 1'b0, "R7 no write", node_we, 0);

    // R8: start pulse during a run is ignored
    build(12, 2); run(nnodes, 1'b1, "R8 busy start");
    build(5, 0);  run(nnodes, 1'b1, "R8 busy start short");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule